// File: doc/BRIEF.md
# Serial-In Parallel-Out Display Driver Register

This block turns a serial bit stream into a wide parallel word that drives display channels. Each rising clock edge moves every bit one stage down a chain of shift stages, with the new serial bit entering the first stage. A bank of storage cells sits between the chain and the outputs. While the capture input is high, the bank is transparent and the outputs follow the chain. When the capture input drops, the bank holds the word it last showed, and the chain keeps accepting new bits.

A blanking input sits at the output side. When it is low, every channel is forced low. The bit in the last stage always appears on a serial output pin. A second device's serial input can take this pin, so several devices form one longer chain. All of them share the clock, capture and blanking lines.

Serial data moves on every clock edge, with no stall and no back-pressure. A host that has no data for a cycle shifts in a filler bit. The block has no valid/ready pair, because it has no point where it could refuse a bit.

Top module: `spd_driver`

## Requirements
- R1: On every rising clock edge with reset released, stage 1 takes `ser_in`, and stage k (k = 2..CHANNELS) takes the old value of stage k-1.
- R2: Output bit `chan_o[k-1]` belongs to stage k. Bit 0 carries the bit that entered most recently, and bit CHANNELS-1 carries the oldest bit.
- R3: `ser_out` equals the last stage with no extra register. A bit on `ser_in` appears on `ser_out` exactly CHANNELS clocks later. Through two chained devices it appears exactly 2*CHANNELS clocks later.
- R4: The levels of `cap_en` and `show_en` have no effect on shifting. The serial output sequence is the same whatever those inputs do.
- R5: While `cap_en` is high, the bank is transparent. With `show_en` high, `chan_o` equals the current stage contents in the same cycle, including right after `cap_en` rises.
- R6: While `cap_en` is low, the bank keeps the word it held when `cap_en` fell, while the chain goes on shifting.
- R7: While `show_en` is low, `chan_o` is all zeros whatever the bank holds. While it is high, `chan_o` shows the bank.
- R8: `rst_n` low on a rising edge clears every stage and every bank cell to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ser_in | input | 1 | Serial data into stage 1 |
| cap_en | input | 1 | Bank transparent when high, holding when low |
| show_en | input | 1 | Outputs shown when high, forced low when low |
| chan_o | output | CHANNELS | Parallel channel outputs, bit 0 = stage 1 |
| ser_out | output | 1 | Last stage, for chaining into the next device |

## Verification
The chain is first filled with random bits while the bank is held. All-zero outputs after that show that the hold is complete. A single 1 is then walked through a cleared chain with the bank open. This pins each stage to its own channel and separates a one-cycle lag in the transparent path from a true pass-through. Random levels on the capture and blanking lines during random shifting compare the serial output against the input history, which exposes any gating of the shift by those controls. A second device fed from the first checks the combined 2*CHANNELS delay, which catches an extra or missing stage at the chaining pin.

// File: rtl/spd_pkg.sv
package spd_pkg;
  localparam int unsigned SPD_CHANNELS_DEF = 32;

  typedef enum logic {
    SPD_BLANK = 1'b0,
    SPD_SHOW  = 1'b1
  } spd_show_e;
endpackage

// File: rtl/spd_shift_chain.sv
module spd_shift_chain #(
  parameter int unsigned N = spd_pkg::SPD_CHANNELS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  output logic [N-1:0] stage_q,
  output logic [N-1:0] stage_nxt,
  output logic         tail_o
);
  localparam int unsigned LAST = N - 1;

  always_comb stage_nxt = {stage_q[LAST-1:0], ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nxt;
  end

  assign tail_o = stage_q[LAST];

  assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (stage_q[0] == $past(ser_in)) &&
             (stage_q[LAST:1] == $past(stage_q[LAST-1:0])));

  assert_clear_chain_R8: assert property (@(posedge clk)
    !rst_n |=> stage_q == '0);
endmodule

// File: rtl/spd_hold_bank.sv
module spd_hold_bank #(
  parameter int unsigned N = spd_pkg::SPD_CHANNELS_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [N-1:0] fresh,
  input  logic [N-1:0] live,
  output logic [N-1:0] view_o
);
  logic [N-1:0] held_q;

  // Holding the post-edge word keeps the view seamless when cap_en falls mid-cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)      held_q <= '0;
    else if (cap_en) held_q <= fresh;
  end

  always_comb view_o = cap_en ? live : held_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(held_q));

  assert_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> held_q == live);

  assert_clear_bank_R8: assert property (@(posedge clk)
    !rst_n |=> held_q == '0);
endmodule

// File: rtl/spd_out_gate.sv
module spd_out_gate #(
  parameter int unsigned N = spd_pkg::SPD_CHANNELS_DEF
) (
  input  logic         show_en,
  input  logic [N-1:0] view,
  output logic [N-1:0] chan_o
);
  import spd_pkg::*;
  spd_show_e mode;

  always_comb mode = spd_show_e'(show_en);

  for (genvar g = 0; g < N; g++) begin : g_chan
    always_comb chan_o[g] = (mode == SPD_SHOW) & view[g];
  end
endmodule

// File: rtl/spd_driver.sv
module spd_driver #(
  parameter int unsigned CHANNELS = spd_pkg::SPD_CHANNELS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_in,
  input  logic                cap_en,
  input  logic                show_en,
  output logic [CHANNELS-1:0] chan_o,
  output logic                ser_out
);
  logic [CHANNELS-1:0] stage_q;
  logic [CHANNELS-1:0] stage_nxt;
  logic [CHANNELS-1:0] view;

  spd_shift_chain #(.N(CHANNELS)) u_chain (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .stage_q(stage_q), .stage_nxt(stage_nxt), .tail_o(ser_out)
  );

  spd_hold_bank #(.N(CHANNELS)) u_bank (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .fresh(stage_nxt), .live(stage_q), .view_o(view)
  );

  spd_out_gate #(.N(CHANNELS)) u_gate (
    .show_en(show_en), .view(view), .chan_o(chan_o)
  );

  assert_tail_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && show_en) |-> chan_o[CHANNELS-1] == ser_out);

  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!show_en && $stable(stage_q)) |-> $countones(chan_o) == 0);
endmodule

// File: tb/test_spd_driver.sv
module test_spd_driver;
  localparam int N = 32;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ser_in = 1'b0, cap_en = 1'b0, show_en = 1'b0;
  logic [N-1:0] chan_o;
  logic ser_out, tail_out;
  logic [N-1:0] tail_chan;

  int n_run = 0, n_fail = 0;
  string tag = "R8";

  bit sq[$];       // sq[0] = newest bit, stage 1
  bit hist[$];     // serial input history for the two-device chain
  logic [N-1:0] m_held = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spd_driver #(.CHANNELS(N)) i_spd_driver (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .cap_en(cap_en),
    .show_en(show_en), .chan_o(chan_o), .ser_out(ser_out));

  spd_driver #(.CHANNELS(N)) i_spd_driver_tail (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_out), .cap_en(cap_en),
    .show_en(show_en), .chan_o(tail_chan), .ser_out(tail_out));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [N-1:0] stages();
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = sq[k];
    return v;
  endfunction

  task automatic clear_model();
    sq.delete(); hist.delete();
    for (int k = 0; k < N; k++) sq.push_back(1'b0);
    for (int k = 0; k < 2*N; k++) hist.push_back(1'b0);
    m_held = '0;
  endtask

  task automatic compare();
    logic [N-1:0] e;
    e = !show_en ? '0 : (cap_en ? stages() : m_held);
    chk(tag, chan_o, e);
    chk("R3", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, sq[N-1]});
    chk("R3 chain", {{(N-1){1'b0}}, tail_out}, {{(N-1){1'b0}}, hist[2*N-1]});
  endtask

  task automatic step(input logic d, input logic l, input logic o, input logic r);
    @(negedge clk);
    ser_in = d; cap_en = l; show_en = o; rst_n = r;
    #1 compare();
    @(posedge clk);
    if (!r) clear_model();
    else begin
      sq.push_front(d); void'(sq.pop_back());
      hist.push_front(d); void'(hist.pop_back());
      if (l) m_held = stages();
    end
  endtask

  initial begin
    clear_model();
    // R8: reset with outputs open
    tag = "R8";
    repeat (3) step($urandom_range(1), 1'b1, 1'b1, 1'b0);
    #1 chk("R8", chan_o, '0);
    chk("R8", {{(N-1){1'b0}}, ser_out}, '0);

    // R6: fill chain with the bank closed; outputs stay at the held zeros
    tag = "R6";
    for (int i = 0; i < N; i++) step($urandom_range(1), 1'b0, 1'b1, 1'b1);
    // R5: open the bank, content must appear in the same cycle
    tag = "R5";
    for (int i = 0; i < 4; i++) step($urandom_range(1), 1'b1, 1'b1, 1'b1);
    tag = "R6";
    for (int i = 0; i < 10; i++) step($urandom_range(1), 1'b0, 1'b1, 1'b1);

    // R7: blanking with the bank open and closed
    tag = "R7";
    for (int i = 0; i < 6; i++) step($urandom_range(1), i[0], 1'b0, 1'b1);

    // R2 / R1: walk a single one through a cleared chain
    tag = "R8";
    step(1'b0, 1'b1, 1'b1, 1'b0);
    tag = "R1";
    step(1'b1, 1'b1, 1'b1, 1'b1);
    #1 chk("R2", chan_o, {{(N-1){1'b0}}, 1'b1});
    for (int k = 1; k < N; k++) begin
      step(1'b0, 1'b1, 1'b1, 1'b1);
      #1 chk("R2", chan_o, {{(N-1){1'b0}}, 1'b1} << k);
    end
    chk("R3", {{(N-1){1'b0}}, ser_out}, {{(N-1){1'b0}}, 1'b1});

    // R4: random control levels while shifting; serial paths must be unaffected
    tag = "R4";
    for (int i = 0; i < 3*N; i++)
      step($urandom_range(1), $urandom_range(1), $urandom_range(1), 1'b1);

    // R8: reset mid-run
    tag = "R8";
    step(1'b1, 1'b0, 1'b1, 1'b0);
    tag = "R6";
    step(1'b1, 1'b0, 1'b1, 1'b1);
    #1 chk("R8", chan_o, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule